// File: doc/BRIEF.md
# Fetch-Counting Single-Step Interrupt Generator

This block lets a debug monitor run exactly one user instruction and then take back control. The monitor writes an 8-bit output port. When the arm bit in that byte changes from 0 to 1, the block starts counting completed opcode fetches. A completed fetch is a low-to-high transition of the active-low fetch strobe `m1_n`. When the count reaches 2^STAGES (four with the default two stages), the block pulls the active-low non-maskable interrupt line `nmi_n` low. That count covers the fetches of the monitor's own return path plus the one user instruction. The interrupt request stays low until the next instruction begins its fetch, which is the next falling edge of `m1_n`.

Every arming is consumed by one firing. To step again, software must write the arm bit low and then high. The fetch strobe is an asynchronous input and passes through a two-flop synchronizer. All state then advances on edges detected in the system clock domain. The counter is a ripple-style chain of toggle stages. Each stage flips when the stage below it goes from 0 to 1. While the block is idle, every stage is held at 1.

Top module: `step_nmi_gen`

## Requirements
- R1: Synchronous active-high reset sets the port latch `port_q` to 0x00, clears the arm state and drives `nmi_n` high. Fetches after a reset cause no interrupt until the block is armed again.
- R2: When `port_wr` is high at a clock edge, `port_q` takes the value of `port_din`. When `port_wr` is low, `port_q` holds its value whatever `port_din` does.
- R3: Bit 3 of the port byte is the arm bit. The block arms only when a write changes that bit from 0 to 1. A write with bit 3 = 1 while the latched bit 3 is already 1 does not arm the block.
- R4: Once armed, `nmi_n` goes low on the 4th completed fetch (rising edge of `m1_n`). Fetches that complete while the block is not armed are not counted.
- R5: After `nmi_n` has gone low, it returns high on the next falling edge of `m1_n`, but only if the block is not armed at that moment. While the block is armed, the low level is held.
- R6: Firing clears the arm state. More fetches cause no further interrupt until a new 0-to-1 write of bit 3.
- R7: `nmi_n` changes at the third rising clock edge after the `m1_n` transition that causes the change.
- R8: While armed, writes that change other bits but leave bit 3 at 1 neither restart nor disturb the fetch count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| m1_n | input | 1 | Asynchronous active-low opcode-fetch strobe |
| port_wr | input | 1 | Write strobe for the step control port |
| port_din | input | 8 | Data byte written to the control port |
| nmi_n | output | 1 | Active-low non-maskable interrupt request, registered |
| port_q | output | 8 | Current contents of the control port latch |

## Verification
The bench builds the block with its defaults: two counter stages, an 8-bit port and arm bit 3. With these values a full arm-to-fire sequence takes only four fetches. That makes it cheap to repeat the cycle many times, including a re-arm while the interrupt is still held low and a reset in the middle of a count. Each fetch holds `m1_n` steady for four clocks, which is longer than the three-edge synchronizer latency. Every expectation therefore has a settled point to be sampled at. A dedicated sequence also samples the output either side of the exact edge where it changes.

// File: rtl/step_nmi_pkg.sv
package step_nmi_pkg;
  // Edge pulses extracted from the synchronized fetch strobe
  typedef struct packed {
    logic rise;  // fetch completed (m1_n low -> high)
    logic fall;  // fetch started   (m1_n high -> low)
  } m1_edge_t;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/m1_edge_sync.sv
module m1_edge_sync
  import step_nmi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     m1_n,
  output m1_edge_t edges
);
  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_DEPTH-2:0], m1_n};
      prev_q <= sync_q[SYNC_DEPTH-1];
    end
  end

  always_comb begin
    edges.rise = sync_q[SYNC_DEPTH-1] & ~prev_q;
    edges.fall = ~sync_q[SYNC_DEPTH-1] & prev_q;
  end
endmodule

// File: rtl/port_arm_latch.sv
module port_arm_latch #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ARM_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic              fire,
  output logic [DATA_W-1:0] q,
  output logic              arm
);
  logic arm_edge;

  // Only a low-to-high change of the latched arm bit counts as a request
  assign arm_edge = wr & din[ARM_BIT] & ~q[ARM_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      arm <= 1'b0;
    end else begin
      if (wr) q <= din;
      if (arm_edge)  arm <= 1'b1;
      else if (fire) arm <= 1'b0;
    end
  end
endmodule

// File: rtl/fetch_counter.sv
module fetch_counter #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              rise,
  output logic [STAGES-1:0] stage_q,
  output logic              fire
);
  logic [STAGES:0] carry;

  assign carry[0] = rise & arm;

  // A stage flips when every stage below it flips from 0 to 1
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] & ~stage_q[i];

    always_ff @(posedge clk) begin
      if (rst || !arm) stage_q[i] <= 1'b1;
      else if (carry[i]) stage_q[i] <= ~stage_q[i];
    end
  end

  // Top stage returning to 1 marks the final fetch of the window
  assign fire = carry[STAGES];
endmodule

// File: rtl/nmi_hold.sv
module nmi_hold (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic fall,
  input  logic arm,
  output logic nmi_n
);
  always_ff @(posedge clk) begin
    if (rst)               nmi_n <= 1'b1;
    else if (fire)         nmi_n <= 1'b0;
    else if (fall && !arm) nmi_n <= 1'b1;
  end
endmodule

// File: rtl/step_nmi_gen.sv
module step_nmi_gen
  import step_nmi_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ARM_BIT = 3,
  parameter int unsigned STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m1_n,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] port_din,
  output logic              nmi_n,
  output logic [DATA_W-1:0] port_q
);
  m1_edge_t          edges;
  logic              arm_q;
  logic              fire;
  logic [STAGES-1:0] stage_q;

  m1_edge_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .m1_n  (m1_n),
    .edges (edges)
  );

  port_arm_latch #(.DATA_W(DATA_W), .ARM_BIT(ARM_BIT)) u_port (
    .clk  (clk),
    .rst  (rst),
    .wr   (port_wr),
    .din  (port_din),
    .fire (fire),
    .q    (port_q),
    .arm  (arm_q)
  );

  fetch_counter #(.STAGES(STAGES)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm_q),
    .rise    (edges.rise),
    .stage_q (stage_q),
    .fire    (fire)
  );

  nmi_hold u_nmi (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .fall  (edges.fall),
    .arm   (arm_q),
    .nmi_n (nmi_n)
  );
endmodule

// File: rtl/step_nmi_gen_chk.sv
module step_nmi_gen_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ARM_BIT = 3,
  parameter int unsigned STAGES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              arm_q,
  input logic [STAGES-1:0] stage_q,
  input logic              nmi_n,
  input logic [DATA_W-1:0] port_q
);
  // R4: the interrupt is only requested out of an armed state
  p_fire_from_arm_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |-> $past(arm_q));

  // R6: firing consumes the arm state
  p_fire_disarms_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |-> !arm_q || $rose(port_q[ARM_BIT]));

  // R5: release is blocked while armed
  p_release_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_n) |-> !$past(arm_q));

  // R3: arming follows a low-to-high change of the latched arm bit
  p_arm_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_q) |-> $rose(port_q[ARM_BIT]));

  // R4: counter stages sit preset while idle
  p_idle_preset_r4: assert property (@(posedge clk) disable iff (rst)
    !arm_q |=> (!arm_q && !$rose(port_q[ARM_BIT])) -> (stage_q == '1));

  // R1: reset leaves the outputs idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (nmi_n && port_q == '0 && !arm_q));
endmodule

bind step_nmi_gen step_nmi_gen_chk #(
  .DATA_W(DATA_W), .ARM_BIT(ARM_BIT), .STAGES(STAGES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .arm_q   (arm_q),
  .stage_q (stage_q),
  .nmi_n   (nmi_n),
  .port_q  (port_q)
);

// File: tb/step_nmi_gen_tb.sv
`timescale 1ns/1ps
module step_nmi_gen_tb;
  localparam int DATA_W  = 8;
  localparam int ARM_BIT = 3;
  localparam int STAGES  = 2;
  localparam int FIRE_AT = 1 << STAGES;

  typedef struct {
    bit              nmi;
    bit [DATA_W-1:0] q;
    string           tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              m1_n = 1'b1;
  logic              port_wr = 1'b0;
  logic [DATA_W-1:0] port_din = '0;
  logic              nmi_n;
  logic [DATA_W-1:0] port_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  exp_t exp_q[$];

  // Reference model state
  bit              m_arm = 0;
  int              m_cnt = 0;
  bit              m_nmi = 1;
  bit [DATA_W-1:0] m_q   = '0;

  always #5 clk = ~clk;

  step_nmi_gen #(.DATA_W(DATA_W), .ARM_BIT(ARM_BIT), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst(rst), .m1_n(m1_n), .port_wr(port_wr),
    .port_din(port_din), .nmi_n(nmi_n), .port_q(port_q)
  );

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.nmi = m_nmi; e.q = m_q; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares outputs as expectations arrive
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      chk(nmi_n === e.nmi, e.tag, $sformatf("nmi_n=%0b", nmi_n), $sformatf("nmi_n=%0b", e.nmi));
      chk(port_q === e.q, e.tag, $sformatf("port_q=%02h", port_q), $sformatf("port_q=%02h", e.q));
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_port(input logic [DATA_W-1:0] v, input string tag);
    @(negedge clk);
    port_wr = 1'b1; port_din = v;
    @(negedge clk);
    port_wr = 1'b0;
    if (v[ARM_BIT] && !m_q[ARM_BIT]) begin
      if (!m_arm) m_cnt = 0;
      m_arm = 1;
    end
    m_q = v;
    push(tag);
  endtask

  task automatic fetch(input string tag);
    @(negedge clk); m1_n = 1'b0;
    wait_cyc(4);
    if (!m_nmi && !m_arm) m_nmi = 1;
    push({tag, " fall"});
    @(negedge clk); m1_n = 1'b1;
    wait_cyc(4);
    if (m_arm) begin
      m_cnt++;
      if (m_cnt == FIRE_AT) begin m_nmi = 0; m_arm = 0; m_cnt = 0; end
    end
    push({tag, " rise"});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    m_arm = 0; m_cnt = 0; m_nmi = 1; m_q = '0;
    @(negedge clk);
    push("R1 reset");
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", "timeout", "finish");
    done = 1;
  end

  initial begin
    do_reset();
    // R2 latch and no arm with bit 3 low; R4 idle fetches ignored
    write_port(8'hA5, "R2 write");
    for (int i = 0; i < 5; i++) fetch("R4 unarmed");
    @(negedge clk); port_din = 8'h3C;
    wait_cyc(3);
    push("R2 no strobe");
    // R4 arm, fire on 4th fetch; R5 release on next fall
    write_port(8'hAD, "R3 arm");
    for (int i = 0; i < FIRE_AT + 1; i++) fetch("R4 step");
    // R6 no further firing; R3 writing bit 3 while already 1 does not arm
    for (int i = 0; i < 5; i++) fetch("R6 disarmed");
    write_port(8'hAD, "R3 rewrite");
    for (int i = 0; i < 5; i++) fetch("R3 no arm");
    // R8 other-bit write mid count
    write_port(8'h00, "R8 clear");
    write_port(8'h08, "R8 arm");
    fetch("R8 a"); fetch("R8 b");
    write_port(8'h0F, "R8 other bits");
    fetch("R8 c"); fetch("R8 d");
    // R7 latency of release: nmi_n low, m1_n high, block disarmed
    wait (exp_q.size() == 0);
    @(negedge clk); m1_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(nmi_n === 1'b0, "R7 before third edge", $sformatf("%0b", nmi_n), "0");
    @(negedge clk);
    chk(nmi_n === 1'b1, "R7 at third edge", $sformatf("%0b", nmi_n), "1");
    wait_cyc(2);
    @(negedge clk); m1_n = 1'b1;
    wait_cyc(4);
    m_nmi = 1;
    // R5 re-arm while interrupt held low: release blocked
    write_port(8'h00, "R5 clear");
    write_port(8'h08, "R5 arm");
    for (int i = 0; i < FIRE_AT; i++) fetch("R5 to fire");
    write_port(8'h00, "R5 clear2");
    write_port(8'h08, "R5 rearm low");
    for (int i = 0; i < FIRE_AT + 1; i++) fetch("R5 held");
    // R1 reset mid-count
    write_port(8'h00, "R1 clear");
    write_port(8'h08, "R1 arm");
    fetch("R1 partial"); fetch("R1 partial");
    do_reset();
    for (int i = 0; i < 5; i++) fetch("R1 after reset");
    wait (exp_q.size() == 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule